// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a single-channel SPI master driven from a 32-bit register port. Software sets the character length, bit order, clock rate and an internal loopback path in a mode register, then writes a word to the transmit register. That write starts one character on the serial pins. When the character has been shifted out, the bits captured from the serial input become readable in the receive register and a receive event is raised. Chip select is left to general-purpose pins under software control.

The serial clock idles low. The output data changes on the falling edge and the input is sampled on the rising edge. One clock period lasts 4·(p+1) system clocks, where p is the prescale field. The character length comes from a 4-bit code. Code 0 selects 32 bits. Codes 1 to 3 select 4 bits. Any other code v selects v+1 bits. A short character occupies the low-order bits of both the transmit and the receive registers.

Two sticky event bits are cleared by writing ones: receiver-not-empty and transmitter-not-full. A mask register selects which events drive the interrupt output. Writing the transmit register has an effect only while the interface is enabled and idle.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the mode register reads 0, the event register reads 0x0000_0100 (only transmitter-not-full set), the mask and receive registers read 0, and both `irq` and `sck` are low.
- R2: The length code in mode bits [23:20] sets the character length. Code 0 gives 32 bits, codes 1 to 3 give 4 bits, and any other code v gives v+1 bits. Each character produces exactly that many rising edges on `sck`.
- R3: With prescale p in mode bits [19:16], `sck` has a period of 4·(p+1) clocks and idles low. Receiver-not-empty becomes visible exactly n·4·(p+1) clock edges after the edge that accepts the transmit write, where n is the character length.
- R4: When mode bit 26 (reverse) is set, the most significant bit of the character is sent first; otherwise the least significant bit is sent first. `mosi` changes after a falling edge of `sck` and is stable at each rising edge.
- R5: Transmit data comes from bits [n-1:0] of the transmit register. The received character is returned in bits [n-1:0] of the receive register, and all higher bits read 0. Input bits are placed in the same order used for output.
- R6: When mode bit 30 (loopback) is set, the output serial data is fed back as the input and the `miso` pin is ignored.
- R7: Event bit 9 (receiver-not-empty) is set when a character completes. Event bit 8 (transmitter-not-full) is set whenever the transmitter is idle and is cleared by an accepted transmit write. Writing a 1 to an event bit clears it, but not on a cycle in which the same bit is being set.
- R8: `irq` is high when any event bit is set together with the mask bit at the same position (bit 9 or bit 8). The mask register reads back those bits.
- R9: While mode bit 24 (enable) is set, a mode write leaves the length and prescale fields unchanged but does update the enable, loopback, reverse and master-select bits (bits 24, 30, 26 and 25).
- R10: A transmit write made while the interface is disabled or a character is in progress is ignored. No clock edges are produced, the transmit register keeps its value, and the character in progress is unchanged.
- R11: Clearing enable during a character aborts it. `sck` returns low and stays low, and receiver-not-empty is not set. A later transfer after re-enabling works normally.
- R12: The registers are at byte offsets mode 0x20, event 0x24, mask 0x28, command 0x2C (plain read/write storage), transmit 0x30 and receive 0x34. Reading the receive register does not clear receiver-not-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | OR of the unmasked events |

## Verification
The hardest situations to reach from the ports are a transmit write that lands in the middle of a character and an enable drop that cuts a character short. Both depend on timing the host write against the serial clock. The bench issues these writes a fixed number of cycles after starting a slow character, then checks the captured output word, the count of clock edges and the event register. A bench-side slave drives `miso` from its own word in the configured bit order and rebuilds the output word on rising edges. The bench sweeps all sixteen length codes with both bit orders, with and without loopback, at two prescale values, so that the clamped short codes and the 32-bit wrap of code 0 are reached. In loopback runs the slave still drives a different word, which shows that the pin is ignored.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 4;
    localparam int PRE_W  = 4;
    localparam int CNT_W  = PRE_W + 2;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int CHR_W  = IDX_W + 1;
    localparam int ADDR_W = 8;
    localparam int MIN_CODE = 3;

    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_EV   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_TX   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_RX   = 8'h34;

    localparam int B_LOOP   = 30;
    localparam int B_REV    = 26;
    localparam int B_MST    = 25;
    localparam int B_EN     = 24;
    localparam int B_LEN_LO = 20;
    localparam int B_PRE_LO = 16;
    localparam int B_NE     = 9;
    localparam int B_NF     = 8;

    typedef struct packed {
        logic             loop;
        logic             rev;
        logic             master;
        logic             en;
        logic [LEN_W-1:0] len_code;
        logic [PRE_W-1:0] pre;
    } mode_t;

    // Decoded character length in bits.
    function automatic logic [CHR_W-1:0] char_bits(input logic [LEN_W-1:0] code);
        if (code == '0)
            return CHR_W'(WORD_W);
        else if (code < LEN_W'(MIN_CODE))
            return CHR_W'(MIN_CODE + 1);
        else
            return CHR_W'(code) + CHR_W'(1);
    endfunction

    function automatic logic [WORD_W-1:0] mode_word(input mode_t m);
        logic [WORD_W-1:0] w;
        w = '0;
        w[B_LOOP] = m.loop;
        w[B_REV]  = m.rev;
        w[B_MST]  = m.master;
        w[B_EN]   = m.en;
        w[B_LEN_LO +: LEN_W] = m.len_code;
        w[B_PRE_LO +: PRE_W] = m.pre;
        return w;
    endfunction

endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [WORD_W-1:0] rx_word,
    output mode_t             cfg,
    output logic              tx_go,
    output logic              ev_ne,
    output logic              ev_nf,
    output logic              irq
);

    logic              wr_mode, wr_ev, wr_mask, wr_cmd, wr_tx;
    logic [1:0]        mask_q;
    logic [WORD_W-1:0] cmd_q, tx_q, rx_q;
    mode_t             next_cfg;

    always_comb begin
        wr_mode = bus_wr && (bus_addr == OFS_MODE);
        wr_ev   = bus_wr && (bus_addr == OFS_EV);
        wr_mask = bus_wr && (bus_addr == OFS_MASK);
        wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
        wr_tx   = bus_wr && (bus_addr == OFS_TX);
        tx_go   = wr_tx && cfg.en && !busy;

        next_cfg.loop     = bus_wdata[B_LOOP];
        next_cfg.rev      = bus_wdata[B_REV];
        next_cfg.master   = bus_wdata[B_MST];
        next_cfg.en       = bus_wdata[B_EN];
        next_cfg.len_code = bus_wdata[B_LEN_LO +: LEN_W];
        next_cfg.pre      = bus_wdata[B_PRE_LO +: PRE_W];
        // Length and rate are frozen while the interface runs.
        if (cfg.en) begin
            next_cfg.len_code = cfg.len_code;
            next_cfg.pre      = cfg.pre;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            ev_ne  <= 1'b0;
            ev_nf  <= 1'b1;
            mask_q <= '0;
            cmd_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else begin
            if (wr_mode) cfg <= next_cfg;
            if (wr_mask) mask_q <= {bus_wdata[B_NE], bus_wdata[B_NF]};
            if (wr_cmd)  cmd_q <= bus_wdata;
            if (tx_go)   tx_q <= bus_wdata;
            if (done)    rx_q <= rx_word;
            ev_ne <= (ev_ne && !(wr_ev && bus_wdata[B_NE])) || done;
            ev_nf <= ((ev_nf && !(wr_ev && bus_wdata[B_NF])) || !busy || done) && !tx_go;
        end
    end

    always_comb begin
        irq = (ev_ne && mask_q[1]) || (ev_nf && mask_q[0]);
        bus_rdata = '0;
        case (bus_addr)
            OFS_MODE: bus_rdata = mode_word(cfg);
            OFS_EV: begin
                bus_rdata[B_NE] = ev_ne;
                bus_rdata[B_NF] = ev_nf;
            end
            OFS_MASK: begin
                bus_rdata[B_NE] = mask_q[1];
                bus_rdata[B_NF] = mask_q[0];
            end
            OFS_CMD: bus_rdata = cmd_q;
            OFS_TX:  bus_rdata = tx_q;
            OFS_RX:  bus_rdata = rx_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_host_clkgen.sv
module spi_host_clkgen
    import spi_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             start,
    input  logic [PRE_W-1:0] pre,
    output logic             sck,
    output logic             rise,
    output logic             fall
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;
    logic             wrap;

    always_comb begin
        // Half period is 2*(pre+1) cycles, so the terminal count is 2*pre+1.
        half_m1 = CNT_W'({pre, 1'b1});
        wrap    = run && !start && (cnt_q == half_m1);
        rise    = wrap && !sck;
        fall    = wrap && sck;
    end

    always_ff @(posedge clk) begin
        if (rst || start || !run) begin
            cnt_q <= '0;
            sck   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            sck   <= ~sck;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
    import spi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [CHR_W-1:0]  n_bits,
    input  logic              msb_first,
    input  logic              loop,
    input  logic              miso_pin,
    input  logic              rise,
    input  logic              fall,
    output logic              busy,
    output logic              mosi,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);

    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  pos;
    logic [CHR_W-1:0]  len_q;
    logic              msb_q;
    logic              last;
    logic              miso_eff;
    logic [WORD_W-1:0] tx_q, acc_q;

    always_comb begin
        // Bit of the character on the wire in this step.
        pos      = msb_q ? IDX_W'(len_q - CHR_W'(1) - CHR_W'(idx)) : idx;
        mosi     = busy && tx_q[pos];
        miso_eff = loop ? mosi : miso_pin;
        last     = (CHR_W'(idx) == len_q - CHR_W'(1));
        done     = busy && fall && last;
        rx_word  = acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            idx   <= '0;
            len_q <= '0;
            msb_q <= 1'b0;
            tx_q  <= '0;
            acc_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            idx   <= '0;
            len_q <= n_bits;
            msb_q <= msb_first;
            tx_q  <= tx_word;
            acc_q <= '0;
        end else if (busy && !en) begin
            busy <= 1'b0;
        end else if (busy) begin
            if (rise) acc_q[pos] <= miso_eff;
            if (fall) begin
                if (last) busy <= 1'b0;
                else      idx  <= idx + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);

    mode_t             cfg;
    logic              tx_go, busy, done, rise, fall, ev_ne, ev_nf;
    logic [WORD_W-1:0] rx_word;

    spi_host_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .done      (done),
        .rx_word   (rx_word),
        .cfg       (cfg),
        .tx_go     (tx_go),
        .ev_ne     (ev_ne),
        .ev_nf     (ev_nf),
        .irq       (irq)
    );

    spi_host_clkgen u_clk (
        .clk   (clk),
        .rst   (rst),
        .run   (busy && cfg.en),
        .start (tx_go),
        .pre   (cfg.pre),
        .sck   (sck),
        .rise  (rise),
        .fall  (fall)
    );

    spi_host_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg.en),
        .start     (tx_go),
        .tx_word   (bus_wdata),
        .n_bits    (char_bits(cfg.len_code)),
        .msb_first (cfg.rev),
        .loop      (cfg.loop),
        .miso_pin  (miso),
        .rise      (rise),
        .fall      (fall),
        .busy      (busy),
        .mosi      (mosi),
        .done      (done),
        .rx_word   (rx_word)
    );

endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk
    import spi_host_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              en,
    input logic [LEN_W-1:0]  len_code,
    input logic [PRE_W-1:0]  pre,
    input logic              busy,
    input logic              sck,
    input logic              tx_go,
    input logic              ev_ne,
    input logic              ev_nf
);

    logic ne_clr;
    assign ne_clr = bus_wr && (bus_addr == OFS_EV) && bus_wdata[B_NE];

    assert_sck_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);

    assert_nf_drop_R7: assert property (@(posedge clk) disable iff (rst)
        tx_go |=> !ev_nf);

    assert_ne_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ev_ne && !ne_clr) |=> ev_ne);

    assert_len_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        en |=> ($stable(len_code) && $stable(pre)));

    assert_abort_R11: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy);

endmodule

bind spi_host_ctrl spi_host_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .en        (cfg.en),
    .len_code  (cfg.len_code),
    .pre       (cfg.pre),
    .busy      (busy),
    .sck       (sck),
    .tx_go     (tx_go),
    .ev_ne     (ev_ne),
    .ev_nf     (ev_nf)
);

// File: tb/sim_spi_host_ctrl.sv
module sim_spi_host_ctrl;
    import spi_host_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [WORD_W-1:0] bus_wdata = '0;
    wire  [WORD_W-1:0] bus_rdata;
    wire               sck, mosi, irq, miso;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    spi_host_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sck       (sck),
        .mosi      (mosi),
        .miso      (miso),
        .irq       (irq)
    );

    always #5 clk = ~clk;

    // Bench slave: drives its word in the configured order, rebuilds mosi.
    logic [31:0] slv_word = '0;
    logic [31:0] mosi_cap = '0;
    int          slv_len = 32;
    bit          slv_rev = 0;
    int          rises = 0;
    int          falls = 0;

    assign miso = (falls < slv_len) ? slv_word[slv_rev ? (slv_len - 1 - falls) : falls] : 1'b0;

    always @(posedge sck) begin
        if (rises < slv_len) mosi_cap[slv_rev ? (slv_len - 1 - rises) : rises] = mosi;
        rises = rises + 1;
    end

    always @(negedge sck) falls = falls + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] mode_val(int code, int p, int rv, int lp, int en);
        return (32'(lp) << 30) | (32'(rv) << 26) | (32'h1 << 25) | (32'(en) << 24)
             | (32'(code) << 20) | (32'(p) << 16);
    endfunction

    function automatic int len_of(int code);
        if (code == 0) return 32;
        if (code < 4) return 4;
        return code + 1;
    endfunction

    function automatic logic [31:0] mask_of(int n);
        return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    task automatic arm(input int n, input bit rv, input logic [31:0] sw);
        slv_len = n; slv_rev = rv; slv_word = sw;
        rises = 0; falls = 0; mosi_cap = '0;
    endtask

    task automatic wait_ne(output int cyc);
        logic [31:0] v;
        cyc = 0;
        rd(OFS_EV, v);
        while (!v[9] && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            rd(OFS_EV, v);
        end
    endtask

    task automatic xfer(input int code, input int p, input int rv, input int lp,
                        input logic [31:0] tx, input logic [31:0] sw);
        logic [31:0] v, ex;
        int n, cyc;
        n = len_of(code);
        wr(OFS_MODE, mode_val(code, p, rv, lp, 0));
        wr(OFS_MODE, mode_val(code, p, rv, lp, 1));
        wr(OFS_EV, 32'hFFFF_FFFF);
        rd(OFS_EV, v);
        chk(v == 32'h100, "R7 idle events", v, 32'h100);
        arm(n, rv[0], sw);
        wr(OFS_TX, tx);
        rd(OFS_EV, v);
        chk(v[8] == 1'b0, "R7 NF cleared by accepted write", v, 32'h0);
        wait_ne(cyc);
        chk(cyc == n * 4 * (p + 1), "R3 cycles to NE", cyc, n * 4 * (p + 1));
        chk(rises == n, "R2 rising edges per character", rises, n);
        chk(sck == 1'b0, "R3 sck idle low", {31'b0, sck}, 32'h0);
        chk(mosi_cap == (tx & mask_of(n)), "R4 serial output order", mosi_cap, tx & mask_of(n));
        rd(OFS_RX, v);
        ex = (lp != 0) ? (tx & mask_of(n)) : (sw & mask_of(n));
        chk(v == ex, (lp != 0) ? "R6 loopback receive" : "R5 right-justified receive", v, ex);
        rd(OFS_EV, v);
        chk(v == 32'h300, "R12 NE kept after receive read", v, 32'h300);
        wr(OFS_EV, 32'h200);
        rd(OFS_EV, v);
        chk(v == 32'h100, "R7 write-one clears NE", v, 32'h100);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cyc, r0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(OFS_MODE, v); chk(v == 32'h0, "R1 mode reset", v, 32'h0);
        rd(OFS_EV, v);   chk(v == 32'h100, "R1 event reset", v, 32'h100);
        rd(OFS_MASK, v); chk(v == 32'h0, "R1 mask reset", v, 32'h0);
        rd(OFS_RX, v);   chk(v == 32'h0, "R1 receive reset", v, 32'h0);
        chk(irq == 1'b0 && sck == 1'b0, "R1 irq and sck low", {30'b0, irq, sck}, 32'h0);

        // R12 command register storage
        wr(OFS_CMD, 32'hC0DE_1234);
        rd(OFS_CMD, v);  chk(v == 32'hC0DE_1234, "R12 command storage", v, 32'hC0DE_1234);
        rd(OFS_MODE, v); chk(v == 32'h0, "R12 command leaves mode", v, 32'h0);

        // Sweep: every length code, both orders, loopback on and off, two rates
        for (int p = 0; p < 2; p++)
            for (int c = 0; c < 16; c++)
                for (int r = 0; r < 2; r++)
                    for (int l = 0; l < 2; l++)
                        xfer(c, p, r, l, (32'h9E37_79B9 * (c + 1)) ^ 32'(p << 3) ^ 32'(r << 1),
                             ~(32'h5A17_C3E1 + 32'(c) * 32'h0101_0101));

        // R8 interrupt masking
        wr(OFS_MASK, 32'h100);
        chk(irq == 1'b1, "R8 NF unmasked while idle", {31'b0, irq}, 32'h1);
        wr(OFS_MASK, 32'h0);
        chk(irq == 1'b0, "R8 all masked", {31'b0, irq}, 32'h0);
        wr(OFS_MASK, 32'h200);
        rd(OFS_MASK, v); chk(v == 32'h200, "R8 mask readback", v, 32'h200);
        chk(irq == 1'b0, "R8 NE masked in but clear", {31'b0, irq}, 32'h0);
        wr(OFS_MODE, mode_val(7, 0, 0, 1, 0));
        wr(OFS_MODE, mode_val(7, 0, 0, 1, 1));
        arm(8, 0, 32'h0);
        wr(OFS_TX, 32'h0000_00A5);
        wait_ne(cyc);
        chk(irq == 1'b1, "R8 irq on NE", {31'b0, irq}, 32'h1);
        wr(OFS_EV, 32'h200);
        chk(irq == 1'b0, "R8 irq drops after clear", {31'b0, irq}, 32'h0);
        wr(OFS_MASK, 32'h0);

        // R9 length and rate locked while enabled
        wr(OFS_MODE, mode_val(5, 0, 0, 0, 0));
        wr(OFS_MODE, mode_val(5, 0, 0, 0, 1));
        wr(OFS_MODE, mode_val(9, 3, 1, 1, 1));
        rd(OFS_MODE, v);
        chk(v == mode_val(5, 0, 1, 1, 1), "R9 locked fields", v, mode_val(5, 0, 1, 1, 1));
        arm(6, 1, 32'h0);
        wr(OFS_TX, 32'h0000_0029);
        wait_ne(cyc);
        chk(cyc == 24, "R9 old length and rate in use", cyc, 24);
        chk(rises == 6, "R9 six-bit character", rises, 6);
        chk(mosi_cap == 32'h29, "R9 output under new order", mosi_cap, 32'h29);

        // R10 transmit write while disabled
        wr(OFS_MODE, mode_val(7, 0, 0, 0, 0));
        wr(OFS_EV, 32'hFFFF_FFFF);
        arm(8, 0, 32'h0);
        wr(OFS_TX, 32'h0000_00FF);
        repeat (100) @(negedge clk);
        chk(rises == 0, "R10 no clock while disabled", rises, 0);
        rd(OFS_EV, v); chk(v == 32'h100, "R10 no event while disabled", v, 32'h100);
        rd(OFS_TX, v); chk(v == 32'h29, "R10 transmit register kept", v, 32'h29);

        // R10 transmit write while busy
        wr(OFS_MODE, mode_val(7, 1, 0, 1, 1));
        arm(8, 0, 32'h0);
        wr(OFS_TX, 32'h0000_003C);
        repeat (5) @(negedge clk);
        wr(OFS_TX, 32'h0000_00C3);
        wait_ne(cyc);
        chk(rises == 8, "R10 single character", rises, 8);
        chk(mosi_cap == 32'h3C, "R10 first word kept on wire", mosi_cap, 32'h3C);
        rd(OFS_RX, v); chk(v == 32'h3C, "R10 receive of first word", v, 32'h3C);
        rd(OFS_TX, v); chk(v == 32'h3C, "R10 busy write dropped", v, 32'h3C);

        // R11 abort by clearing enable
        wr(OFS_MODE, mode_val(0, 1, 0, 0, 0));
        wr(OFS_MODE, mode_val(0, 1, 0, 0, 1));
        wr(OFS_EV, 32'hFFFF_FFFF);
        arm(32, 0, 32'hFFFF_FFFF);
        wr(OFS_TX, 32'h1234_5678);
        repeat (40) @(negedge clk);
        wr(OFS_MODE, mode_val(0, 1, 0, 0, 0));
        repeat (2) @(negedge clk);
        r0 = rises;
        chk(r0 > 0, "R11 character had started", r0, 1);
        repeat (400) @(negedge clk);
        chk(rises == r0, "R11 no clock after abort", rises, r0);
        chk(sck == 1'b0, "R11 sck low after abort", {31'b0, sck}, 32'h0);
        rd(OFS_EV, v); chk(v == 32'h100, "R11 no NE after abort", v, 32'h100);
        xfer(3, 0, 1, 1, 32'h0000_000B, 32'h0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule